// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block holds the sticky event flags of a USB device controller. It watches the raw D+/D- line pair and the selected bus speed, and it runs three dwell timers on that pair: one for a resume (K) state, one for bus idle (J), and one for bus reset (SE0). It also takes single-cycle event pulses from the protocol engine for token completion, start-of-frame and a sent stall handshake. Each event sets a flag that stays set until software clears it.

Software reaches the block through a small register port with two addresses. At select 0 is the status word. A full-word write to it clears every flag whose bit position holds a 1. At select 1 is an interrupt-enable word. The error bit is not stored. It is read-only and is formed from the controller's error flags and their enable mask.

The combined interrupt output is active when any enabled status bit is set. Clearing the token-complete flag produces a one-cycle strobe that advances the external transfer-status FIFO. The dwell thresholds are derived from the `CLK_KHZ` parameter: 2.5 µs for resume and reset, and 3 ms for idle, both rounded up to whole cycles.

Top module: `usbd_event_flags`

## Requirements
- R1: Status bits 15 to 8 and bit 6 always read 0, including after writes of all ones.
- R2: A write at select 0 clears each status flag whose bit position holds a 1. A 0 in a position leaves that flag unchanged. Writes at select 1 never change the flags.
- R3: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.
- R4: Bit 5 (resume) sets once a K state has been present for RESUME_CYC = ceil(CLK_KHZ/400) consecutive clocks. With `bus_lines` = {D+, D-}, K is 2'b01 at full speed (`low_speed`=0) and 2'b10 at low speed (`low_speed`=1).
- R5: Each dwell timer starts counting again from zero whenever its monitored line condition is interrupted, even for a single cycle.
- R6: Bit 4 (idle) sets once a J state (2'b10 at full speed, 2'b01 at low speed) has been present for IDLE_CYC = 3*CLK_KHZ consecutive clocks.
- R7: Bit 0 (bus reset) sets once SE0 (2'b00) has been present for RESET_CYC = ceil(CLK_KHZ/400) consecutive clocks. After it sets, it cannot set again until SE0 has ended and the flag has been cleared.
- R8: Bit 1 reads as the OR of `err_flags & err_enable`. Writes do not affect it.
- R9: `stat_fifo_pop` is high for exactly one cycle, in the cycle after a select-0 write with bit 3 = 1 while bit 3 was set. No strobe occurs if bit 3 was already clear.
- R10: A `tok_done` pulse sets bit 3. A `stall_sent` pulse sets bit 7. Either a `sof_token` or a `sof_thresh` pulse sets bit 2. Each appears in the cycle after the pulse.
- R11: The enable word at select 1 reads back masked to the implemented bits (0x00BF). `irq` is high exactly when some status bit and its enable bit are both 1.
- R12: After reset, the status word, the enable word, `irq` and `stat_fifo_pop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_lines | input | 2 | Synchronized {D+, D-} line levels |
| low_speed | input | 1 | 1 = low-speed line polarity, 0 = full speed |
| tok_done | input | 1 | Token processing complete pulse |
| sof_token | input | 1 | Start-of-frame token received pulse |
| sof_thresh | input | 1 | Start-of-frame threshold reached pulse |
| stall_sent | input | 1 | Stall handshake sent pulse |
| err_flags | input | ERR_W | Error condition flags |
| err_enable | input | ERR_W | Error flag enable mask |
| reg_sel | input | 1 | Register select: 0 status, 1 interrupt enable |
| reg_wr | input | 1 | Full-word write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| status | output | 16 | Status word |
| irq | output | 1 | Combined interrupt request |
| stat_fifo_pop | output | 1 | One-cycle transfer-status FIFO advance |

## Verification
The bench holds each line state for one cycle less than its threshold and then for exactly the threshold. This shows that every timer fires on its exact count and not early. Interrupted runs tell a timer that restarts apart from one that only pauses. The same D+/D- pattern is applied at both speeds to confirm that the K/J polarity follows the speed select. The register tests combine a write of 0, partial clears, clears that coincide with a set, writes at the enable address, and clears of an already-clear token bit. Together these separate the W1C, set-wins and pop-strobe behaviour from simple register overwrite.

// File: rtl/usbd_flags_pkg.sv
// Shared constants and types for the USB device event flag register.
// Assumes a 16-bit register word with flags in the low byte.
package usbd_flags_pkg;
    localparam int REG_W     = 16;
    localparam int BIT_RST   = 0;
    localparam int BIT_ERR   = 1;
    localparam int BIT_SOF   = 2;
    localparam int BIT_TOK   = 3;
    localparam int BIT_IDLE  = 4;
    localparam int BIT_RES   = 5;
    localparam int BIT_STALL = 7;

    // Bits that exist in the status word, and the subset held in flops.
    localparam logic [REG_W-1:0] IMPL_MASK   = 16'h00BF;
    localparam logic [REG_W-1:0] STICKY_MASK = 16'h00BD;

    typedef struct packed {
        logic k;
        logic j;
        logic se0;
    } line_t;
endpackage

// File: rtl/usbd_line_decode.sv
// Decodes the synchronized D+/D- pair into J, K and SE0 for the chosen speed.
// Assumes the inputs are already synchronized to clk. Purely combinational.
module usbd_line_decode
    import usbd_flags_pkg::*;
(
    input  logic [1:0] bus_lines,
    input  logic       low_speed,
    output line_t      line
);
    logic diff_one;
    logic diff_zero;

    // Classify the pair and map the differential level to J/K by speed.
    always_comb begin
        diff_one  = bus_lines[1] & ~bus_lines[0];
        diff_zero = ~bus_lines[1] & bus_lines[0];
        line.se0  = ~bus_lines[1] & ~bus_lines[0];
        line.k    = low_speed ? diff_one  : diff_zero;
        line.j    = low_speed ? diff_zero : diff_one;
    end
endmodule

// File: rtl/usbd_dwell_timer.sv
// Counts consecutive cycles of a condition. It pulses `hit` for one cycle
// on the THRESH-th consecutive cycle. It restarts from zero whenever the
// condition drops, and saturates so that it fires only once per run.
// Assumes THRESH >= 1.
module usbd_dwell_timer #(
    parameter int THRESH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);
    localparam logic [CW-1:0] TOP  = CW'(THRESH);

    logic [CW-1:0] cnt;

    // Count while the condition holds; clear when it breaks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Fire on the cycle that completes the run.
    assign hit = cond && (cnt == LAST);

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));
    assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/usbd_sticky_bank.sv
// Bank of write-1-to-clear sticky flags. A set pulse wins over a clear in
// the same cycle. Only positions in MASK exist; the others stay 0.
module usbd_sticky_bank #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] clr_req,
    output logic [W-1:0] flags
);
    // Apply clears, then sets, so that a set takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= ((flags & ~clr_req) | set_pulse) & MASK;
        end
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_pulse & MASK) != '0) |=>
        ((flags & $past(set_pulse & MASK)) == $past(set_pulse & MASK)));
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_req & ~set_pulse & MASK) != '0) |=>
        ((flags & $past(clr_req & ~set_pulse & MASK)) == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (((set_pulse | clr_req) & MASK) == '0) |=> $stable(flags));
endmodule

// File: rtl/usbd_event_flags.sv
// USB device interrupt status register. It combines the line-state dwell
// timers and the protocol-engine event pulses into sticky W1C flags, adds a
// read-only masked error bit, an interrupt-enable word, a combined interrupt
// line and a transfer-status FIFO pop strobe.
// Assumes bus_lines is synchronized to clk and event pulses last one cycle.
module usbd_event_flags
    import usbd_flags_pkg::*;
#(
    parameter int CLK_KHZ = 48000,
    parameter int ERR_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_lines,
    input  logic             low_speed,
    input  logic             tok_done,
    input  logic             sof_token,
    input  logic             sof_thresh,
    input  logic             stall_sent,
    input  logic [ERR_W-1:0] err_flags,
    input  logic [ERR_W-1:0] err_enable,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic [15:0]      status,
    output logic             irq,
    output logic             stat_fifo_pop
);
    localparam int RESUME_CYC = (CLK_KHZ + 399) / 400;
    localparam int RESET_CYC  = (CLK_KHZ + 399) / 400;
    localparam int IDLE_CYC   = CLK_KHZ * 3;

    line_t             line;
    logic              resume_hit;
    logic              idle_hit;
    logic              rst_hit;
    logic              rst_set;
    logic              rst_lock;
    logic              err_bit;
    logic [REG_W-1:0]  set_v;
    logic [REG_W-1:0]  clr_v;
    logic [REG_W-1:0]  flags_q;
    logic [REG_W-1:0]  irq_en;

    usbd_line_decode u_dec (
        .bus_lines (bus_lines),
        .low_speed (low_speed),
        .line      (line)
    );

    usbd_dwell_timer #(.THRESH(RESUME_CYC)) u_resume_tmr (
        .clk(clk), .rst_n(rst_n), .cond(line.k), .hit(resume_hit)
    );
    usbd_dwell_timer #(.THRESH(IDLE_CYC)) u_idle_tmr (
        .clk(clk), .rst_n(rst_n), .cond(line.j), .hit(idle_hit)
    );
    usbd_dwell_timer #(.THRESH(RESET_CYC)) u_reset_tmr (
        .clk(clk), .rst_n(rst_n), .cond(line.se0), .hit(rst_hit)
    );

    // Block a second reset flag until SE0 has ended and the flag was cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_lock <= 1'b0;
        end else if (rst_set) begin
            rst_lock <= 1'b1;
        end else if (!line.se0 && !flags_q[BIT_RST]) begin
            rst_lock <= 1'b0;
        end
    end

    assign rst_set = rst_hit && !rst_lock;

    // Gather the hardware set sources into bit positions.
    always_comb begin
        set_v            = '0;
        set_v[BIT_RST]   = rst_set;
        set_v[BIT_SOF]   = sof_token | sof_thresh;
        set_v[BIT_TOK]   = tok_done;
        set_v[BIT_IDLE]  = idle_hit;
        set_v[BIT_RES]   = resume_hit;
        set_v[BIT_STALL] = stall_sent;
    end

    // Software clears come only from full-word writes to the status word.
    assign clr_v = (reg_wr && !reg_sel) ? reg_wdata : '0;

    usbd_sticky_bank #(.W(REG_W), .MASK(STICKY_MASK)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_v),
        .clr_req   (clr_v),
        .flags     (flags_q)
    );

    // Hold the interrupt-enable word, keeping only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
        end else if (reg_wr && reg_sel) begin
            irq_en <= reg_wdata & IMPL_MASK;
        end
    end

    // Strobe the FIFO pop when a set token flag is written with a 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_fifo_pop <= 1'b0;
        end else begin
            stat_fifo_pop <= reg_wr && !reg_sel && reg_wdata[BIT_TOK]
                             && flags_q[BIT_TOK];
        end
    end

    // Form the read-only error bit, the status word, irq and the read mux.
    always_comb begin
        err_bit          = |(err_flags & err_enable);
        status           = flags_q;
        status[BIT_ERR]  = err_bit;
        irq              = |(status & irq_en);
        reg_rdata        = reg_sel ? irq_en : status;
    end

    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15:8] == 8'h00) && !status[6]);
    assert_reset_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[BIT_RST]) |-> !$past(rst_lock));
    assert_pop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_fifo_pop |-> (!flags_q[BIT_TOK] || $past(tok_done)));
endmodule

// File: tb/sim_usbd_event_flags.sv
module sim_usbd_event_flags;
    localparam int CLK_KHZ = 4000;
    localparam int RES_N   = 10;
    localparam int RST_N   = 10;
    localparam int IDLE_N  = 12000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_lines = 2'b11;
    logic        low_speed = 1'b0;
    logic        tok_done = 1'b0, sof_token = 1'b0, sof_thresh = 1'b0, stall_sent = 1'b0;
    logic [7:0]  err_flags = 8'h00, err_enable = 8'h00;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata, status;
    logic        irq, stat_fifo_pop;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usbd_event_flags #(.CLK_KHZ(CLK_KHZ), .ERR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_lines(bus_lines), .low_speed(low_speed),
        .tok_done(tok_done), .sof_token(sof_token), .sof_thresh(sof_thresh),
        .stall_sent(stall_sent), .err_flags(err_flags), .err_enable(err_enable),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .status(status), .irq(irq),
        .stat_fifo_pop(stat_fifo_pop)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 status", status, 16'h0000);
        check("R12 irq", {15'd0, irq}, 16'h0000);
        check("R12 pop", {15'd0, stat_fifo_pop}, 16'h0000);
        reg_sel = 1'b1; tick(1);
        check("R12 enable", reg_rdata, 16'h0000);
        reg_sel = 1'b0;
    endtask

    task automatic t_events();
        tok_done = 1; tick(1); tok_done = 0;
        check("R10 token", status, 16'h0008);
        stall_sent = 1; tick(1); stall_sent = 0;
        check("R10 stall", status, 16'h0088);
        sof_thresh = 1; tick(1); sof_thresh = 0;
        check("R10 sof threshold", status, 16'h008C);
        wr(0, 16'hFFFF);
        check("R2 clear all", status, 16'h0000);
        check("R1 upper zero", status & 16'hFF40, 16'h0000);
        sof_token = 1; tick(1); sof_token = 0;
        check("R10 sof token", status, 16'h0004);
        wr(0, 16'h0004);
    endtask

    task automatic t_w1c();
        tok_done = 1; sof_token = 1; stall_sent = 1; tick(1);
        tok_done = 0; sof_token = 0; stall_sent = 0;
        wr(0, 16'h0000);
        check("R2 write zero keeps", status, 16'h008C);
        wr(0, 16'h0004);
        check("R2 partial clear", status, 16'h0088);
        wr(0, 16'h0008);
        check("R2 token cleared", status, 16'h0080);
        check("R9 pop on clear", {15'd0, stat_fifo_pop}, 16'h0001);
        tick(1);
        check("R9 pop one cycle", {15'd0, stat_fifo_pop}, 16'h0000);
        wr(0, 16'h0008);
        check("R9 no pop when clear", {15'd0, stat_fifo_pop}, 16'h0000);
        wr(1, 16'h0000);
        check("R2 enable write keeps flags", status, 16'h0080);
        wr(0, 16'h0080);
        check("R2 stall cleared", status, 16'h0000);
    endtask

    task automatic t_setwins();
        tok_done = 1; tick(1); tok_done = 0;
        tok_done = 1; reg_sel = 0; reg_wr = 1; reg_wdata = 16'h0008;
        tick(1);
        tok_done = 0; reg_wr = 0;
        check("R3 set wins", status, 16'h0008);
        check("R9 pop with set", {15'd0, stat_fifo_pop}, 16'h0001);
        wr(0, 16'h0008);
        check("R3 later clear", status, 16'h0000);
        tick(1);
    endtask

    task automatic t_error();
        err_flags = 8'h10; err_enable = 8'h01; tick(1);
        check("R8 masked off", status, 16'h0000);
        err_enable = 8'h11; tick(1);
        check("R8 enabled", status, 16'h0002);
        wr(0, 16'h0002);
        check("R8 read only", status, 16'h0002);
        err_flags = 8'h00; tick(1);
        check("R8 follows flags", status, 16'h0000);
        err_enable = 8'h00;
    endtask

    task automatic t_resume();
        low_speed = 0; bus_lines = 2'b01;
        tick(RES_N - 1);
        check("R4 fs early", status, 16'h0000);
        tick(1);
        check("R4 fs K", status, 16'h0020);
        bus_lines = 2'b11; wr(0, 16'h0020);
        bus_lines = 2'b01; tick(6);
        bus_lines = 2'b11; tick(1);
        bus_lines = 2'b01; tick(RES_N - 1);
        check("R5 restart", status, 16'h0000);
        tick(1);
        check("R5 after full run", status, 16'h0020);
        bus_lines = 2'b11; wr(0, 16'h0020);
        low_speed = 1; bus_lines = 2'b01; tick(RES_N + 2);
        check("R4 ls pattern is J", status, 16'h0000);
        bus_lines = 2'b10; tick(RES_N);
        check("R4 ls K", status, 16'h0020);
        bus_lines = 2'b11; low_speed = 0; wr(0, 16'h0020);
    endtask

    task automatic t_idle();
        bus_lines = 2'b10; tick(IDLE_N - 1);
        check("R6 idle early", status, 16'h0000);
        tick(1);
        check("R6 idle", status, 16'h0010);
        bus_lines = 2'b11; wr(0, 16'h0010);
    endtask

    task automatic t_busreset();
        bus_lines = 2'b00; tick(RST_N - 1);
        check("R7 reset early", status, 16'h0000);
        tick(1);
        check("R7 reset", status, 16'h0001);
        wr(0, 16'h0001); tick(20);
        check("R7 no reset while SE0", status, 16'h0000);
        bus_lines = 2'b11; tick(2);
        bus_lines = 2'b00; tick(RST_N);
        check("R7 new reset", status, 16'h0001);
        bus_lines = 2'b11; wr(0, 16'h0001);
    endtask

    task automatic t_irq();
        wr(1, 16'hFFFF);
        reg_sel = 1; tick(1);
        check("R11 enable readback", reg_rdata, 16'h00BF);
        reg_sel = 0;
        check("R11 no irq", {15'd0, irq}, 16'h0000);
        stall_sent = 1; tick(1); stall_sent = 0;
        check("R11 irq stall", {15'd0, irq}, 16'h0001);
        wr(1, 16'h0008);
        check("R11 irq masked", {15'd0, irq}, 16'h0000);
        tok_done = 1; tick(1); tok_done = 0;
        check("R11 irq token", {15'd0, irq}, 16'h0001);
        wr(0, 16'hFFFF);
        check("R11 irq cleared", {15'd0, irq}, 16'h0000);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_events();
        t_w1c();
        t_setwins();
        t_error();
        t_resume();
        t_idle();
        t_busreset();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule